// File: doc/BRIEF.md
# Buffered Serial Data Path with Hardware Flow Control

This block sits between a serializer/deserializer pair and the host side of a serial port. It holds up to 64 received characters, each stored together with three error flags, and up to 64 characters waiting to be transmitted. It reports fill levels and raises the request-to-send line, a receive service request and a transmit service request from the receive fill level measured against one of four selectable thresholds.

Four small state machines do the control work. The RTS machine has states RTS_GO (line asserted) and RTS_STOP. In automatic mode it moves RTS_GO to RTS_STOP when the receive level is at or above the threshold, and RTS_STOP to RTS_GO when the level is below it. In manual mode it follows a software value. The receive request machine moves RDY_WAIT to RDY_REQ when the level reaches the threshold, and RDY_REQ to RDY_WAIT only when the buffer is empty. The transmit request machine moves TXR_REQ to TXR_WAIT when the transmit buffer fills, and TXR_WAIT to TXR_REQ when it empties. The transmit gate has four states. TXG_IDLE goes to TXG_OFFER, or to TXG_HELD when clear-to-send blocks. TXG_OFFER goes to TXG_SEND when the serializer takes a character, or to TXG_HELD if clear-to-send drops first. TXG_SEND goes to TXG_IDLE, TXG_OFFER or TXG_HELD when the character is done. TXG_HELD goes to TXG_OFFER when clear-to-send returns, or to TXG_IDLE if nothing is queued.

The serializer reads `tx_char` while `tx_valid` is high and pulses `ser_take` when it starts a character. It pulses `ser_done` when the last stop bit has gone out. Clear-to-send gating therefore acts only between characters.

Top module: `serial_flow_buffer`

## Requirements
- R1: Receive entries come out in push order, each with its 3-bit error field unchanged (bit 0 parity, bit 1 framing, bit 2 break). `rx_level` counts stored entries, and a push and a pop in the same cycle leave it unchanged.
- R2: A receive push while the buffer holds 64 entries is discarded. `rx_overrun` then reads 1 from the next cycle and stays 1 until `ovr_clr` is high on a cycle without such a push.
- R3: A transmit write while 64 entries are held is dropped, and `tx_full` stays high.
- R4: `trig_sel` selects the receive threshold: 0 gives 1 entry, 1 gives 16, 2 gives 32 and 3 gives 56.
- R5: With `auto_rts_en` high, `rts_out` is 0 in the cycle after any cycle whose receive level is at or above the threshold. It is 1 in the cycle after any cycle whose level is below it.
- R6: With `auto_rts_en` low, `rts_out` equals the previous cycle's `rts_manual`.
- R7: `rx_dma_rdy` rises the cycle after the receive level reaches the threshold. It stays high until the cycle after the level is 0.
- R8: `tx_dma_rdy` falls the cycle after the transmit buffer is full, rises the cycle after it is empty, and holds in between.
- R9: With `auto_cts_en` high and `cts_in` low, no new character is offered (`tx_valid` stays low). A character already taken completes normally, and the next is held until `cts_in` returns.
- R10: With `auto_cts_en` low, `cts_in` has no effect on offering characters.
- R11: A receive pop on an empty buffer changes nothing.
- R12: After reset the buffers are empty, `rts_out`=1, `rx_dma_rdy`=0, `tx_dma_rdy`=1, `tx_valid`=0 and `rx_overrun`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_push | input | 1 | Deserializer delivers a character |
| rx_char | input | 8 | Received character |
| rx_err_in | input | 3 | Error flags of the received character |
| rx_pop | input | 1 | Host removes the head entry |
| rx_head_char | output | 8 | Character at the receive head |
| rx_head_err | output | 3 | Error flags at the receive head |
| rx_level | output | 7 | Receive entries held |
| rx_empty | output | 1 | Receive buffer empty |
| rx_overrun | output | 1 | Sticky overrun flag |
| ovr_clr | input | 1 | Clears the overrun flag |
| trig_sel | input | 2 | Receive threshold select |
| auto_rts_en | input | 1 | Automatic RTS mode |
| rts_manual | input | 1 | RTS value in manual mode |
| rts_out | output | 1 | Request-to-send, 1 = ready to receive |
| rx_dma_rdy | output | 1 | Receive service request |
| tx_wr | input | 1 | Host writes a character |
| tx_wdata | input | 8 | Character to transmit |
| tx_level | output | 7 | Transmit entries held |
| tx_full | output | 1 | Transmit buffer full |
| tx_dma_rdy | output | 1 | Transmit service request |
| auto_cts_en | input | 1 | Automatic CTS gating |
| cts_in | input | 1 | Clear-to-send, 1 = peer ready |
| ser_take | input | 1 | Serializer starts the offered character |
| ser_done | input | 1 | Serializer finished a character |
| tx_valid | output | 1 | A character is offered |
| tx_char | output | 8 | Offered character |

## Verification
A wrong count or pointer shows at `rx_level`, `tx_level` or the head outputs on the next clock. A wrong RTS or request state shows one cycle after the level crosses the threshold. A gate that leaves TXG_HELD early raises `tx_valid` within one cycle while `cts_in` is low. A gate that stays there leaves `tx_level` frozen after clear-to-send returns. The bench compares every output with a queue-based model on every cycle, so each of these faults is caught within one or two cycles of its cause.

// File: rtl/sfb_pkg.sv
package sfb_pkg;

    typedef enum logic [1:0] {
        TXG_IDLE,
        TXG_OFFER,
        TXG_SEND,
        TXG_HELD
    } txg_state_t;

    typedef enum logic {
        RTS_GO,
        RTS_STOP
    } rts_state_t;

    typedef enum logic {
        RDY_WAIT,
        RDY_REQ
    } rdy_state_t;

    typedef enum logic {
        TXR_REQ,
        TXR_WAIT
    } txr_state_t;

    // Threshold for each select code, scaled from the buffer depth
    function automatic int unsigned trig_of(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return 1;
            2'd1:    return depth / 4;
            2'd2:    return depth / 2;
            default: return depth - depth / 8;
        endcase
    endfunction

endpackage

// File: rtl/sfb_fifo.sv
module sfb_fifo #(
    parameter int WIDTH = 11,
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] din,
    input  logic             pop,
    output logic [WIDTH-1:0] dout,
    output logic [LW-1:0]    level,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [LW-1:0] CAP  = LW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [LW-1:0]    count;
    logic             do_push;
    logic             do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];
    assign level   = count;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CAP);
    a_r1_push_pop_balance: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !empty && !full) |=> $stable(count));
    a_r2_full_push_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop) |=> full);
    a_r11_empty_pop_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/sfb_rx_flow.sv
module sfb_rx_flow
    import sfb_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [LW-1:0] level,
    input  logic [1:0]    trig_sel,
    input  logic          auto_rts_en,
    input  logic          rts_manual,
    output logic          rts_out,
    output logic          dma_rdy
);
    rts_state_t    rts_q, rts_d;
    rdy_state_t    rdy_q, rdy_d;
    logic [LW-1:0] trig;
    logic          at_trig;

    assign trig    = LW'(trig_of(trig_sel, DEPTH));
    assign at_trig = (level >= trig);

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rts_q <= RTS_GO;
            rdy_q <= RDY_WAIT;
        end else begin
            rts_q <= rts_d;
            rdy_q <= rdy_d;
        end
    end

    // Next-state logic
    always_comb begin
        rts_d = rts_q;
        if (!auto_rts_en) begin
            rts_d = rts_manual ? RTS_GO : RTS_STOP;
        end else begin
            unique case (rts_q)
                RTS_GO:   if (at_trig)  rts_d = RTS_STOP;
                RTS_STOP: if (!at_trig) rts_d = RTS_GO;
            endcase
        end

        rdy_d = rdy_q;
        unique case (rdy_q)
            RDY_WAIT: if (at_trig)       rdy_d = RDY_REQ;
            RDY_REQ:  if (level == '0)   rdy_d = RDY_WAIT;
        endcase
    end

    // Outputs
    always_comb begin
        rts_out = (rts_q == RTS_GO);
        dma_rdy = (rdy_q == RDY_REQ);
    end

    a_r5_rts_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && at_trig) |=> !rts_out);
    a_r5_rts_returns: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_rts_en && !at_trig) |=> rts_out);
    a_r6_manual_high: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_rts_en && rts_manual) |=> rts_out);
    a_r6_manual_low: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_rts_en && !rts_manual) |=> !rts_out);
    a_r7_rdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rdy && level != '0) |=> dma_rdy);

endmodule

// File: rtl/sfb_tx_flow.sv
module sfb_tx_flow
    import sfb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic empty,
    input  logic full,
    input  logic auto_cts_en,
    input  logic cts_in,
    input  logic ser_take,
    input  logic ser_done,
    output logic pop,
    output logic valid,
    output logic dma_rdy
);
    txg_state_t st_q, st_d;
    txr_state_t rq_q, rq_d;
    logic       cts_ok;

    assign cts_ok = !auto_cts_en || cts_in;

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= TXG_IDLE;
            rq_q <= TXR_REQ;
        end else begin
            st_q <= st_d;
            rq_q <= rq_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TXG_IDLE: begin
                if (!empty) st_d = cts_ok ? TXG_OFFER : TXG_HELD;
            end
            TXG_OFFER: begin
                if (ser_take)     st_d = TXG_SEND;
                else if (!cts_ok) st_d = TXG_HELD;
            end
            TXG_SEND: begin
                if (ser_done) begin
                    if (empty)       st_d = TXG_IDLE;
                    else if (cts_ok) st_d = TXG_OFFER;
                    else             st_d = TXG_HELD;
                end
            end
            TXG_HELD: begin
                if (empty)       st_d = TXG_IDLE;
                else if (cts_ok) st_d = TXG_OFFER;
            end
        endcase

        rq_d = rq_q;
        unique case (rq_q)
            TXR_REQ:  if (full)  rq_d = TXR_WAIT;
            TXR_WAIT: if (empty) rq_d = TXR_REQ;
        endcase
    end

    // Outputs
    always_comb begin
        valid   = (st_q == TXG_OFFER);
        pop     = valid && ser_take;
        dma_rdy = (rq_q == TXR_REQ);
    end

    a_r9_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> !empty);
    a_r9_no_offer_when_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !cts_in && st_q != TXG_OFFER) |=> st_q != TXG_OFFER);
    a_r8_txrdy_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_rdy && !full) |=> dma_rdy);
    a_r8_txrdy_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_rdy && !empty) |=> !dma_rdy);

endmodule

// File: rtl/serial_flow_buffer.sv
module serial_flow_buffer #(
    parameter int DATA_W = 8,
    parameter int ERR_W  = 3,
    parameter int DEPTH  = 64,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_push,
    input  logic [DATA_W-1:0] rx_char,
    input  logic [ERR_W-1:0]  rx_err_in,
    input  logic              rx_pop,
    output logic [DATA_W-1:0] rx_head_char,
    output logic [ERR_W-1:0]  rx_head_err,
    output logic [LW-1:0]     rx_level,
    output logic              rx_empty,
    output logic              rx_overrun,
    input  logic              ovr_clr,
    input  logic [1:0]        trig_sel,
    input  logic              auto_rts_en,
    input  logic              rts_manual,
    output logic              rts_out,
    output logic              rx_dma_rdy,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_wdata,
    output logic [LW-1:0]     tx_level,
    output logic              tx_full,
    output logic              tx_dma_rdy,
    input  logic              auto_cts_en,
    input  logic              cts_in,
    input  logic              ser_take,
    input  logic              ser_done,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_char
);
    localparam int RXW = DATA_W + ERR_W;

    logic [RXW-1:0] rx_dout;
    logic           rx_full;
    logic           tx_empty;
    logic           tx_pop;
    logic           ovr_q;

    sfb_fifo #(.WIDTH(RXW), .DEPTH(DEPTH), .LW(LW)) u_rx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (rx_push),
        .din   ({rx_err_in, rx_char}),
        .pop   (rx_pop),
        .dout  (rx_dout),
        .level (rx_level),
        .empty (rx_empty),
        .full  (rx_full)
    );

    assign rx_head_char = rx_dout[DATA_W-1:0];
    assign rx_head_err  = rx_dout[DATA_W +: ERR_W];

    sfb_fifo #(.WIDTH(DATA_W), .DEPTH(DEPTH), .LW(LW)) u_tx_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (tx_wr),
        .din   (tx_wdata),
        .pop   (tx_pop),
        .dout  (tx_char),
        .level (tx_level),
        .empty (tx_empty),
        .full  (tx_full)
    );

    sfb_rx_flow #(.DEPTH(DEPTH), .LW(LW)) u_rx_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .level       (rx_level),
        .trig_sel    (trig_sel),
        .auto_rts_en (auto_rts_en),
        .rts_manual  (rts_manual),
        .rts_out     (rts_out),
        .dma_rdy     (rx_dma_rdy)
    );

    sfb_tx_flow u_tx_flow (
        .clk         (clk),
        .rst_n       (rst_n),
        .empty       (tx_empty),
        .full        (tx_full),
        .auto_cts_en (auto_cts_en),
        .cts_in      (cts_in),
        .ser_take    (ser_take),
        .ser_done    (ser_done),
        .pop         (tx_pop),
        .valid       (tx_valid),
        .dma_rdy     (tx_dma_rdy)
    );

    // Sticky overrun: a lost character beats a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ovr_q <= 1'b0;
        else if (rx_push && rx_full)  ovr_q <= 1'b1;
        else if (ovr_clr)             ovr_q <= 1'b0;
    end

    assign rx_overrun = ovr_q;

    a_r2_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_push && rx_full) |=> rx_overrun);
    a_r2_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_overrun && !ovr_clr) |=> rx_overrun);

endmodule

// File: tb/test_serial_flow_buffer.sv
`timescale 1ns/1ps
module test_serial_flow_buffer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_push = 0, rx_pop = 0, ovr_clr = 0;
    logic [7:0] rx_char = 0;
    logic [2:0] rx_err_in = 0;
    logic [7:0] rx_head_char;
    logic [2:0] rx_head_err;
    logic [6:0] rx_level, tx_level;
    logic       rx_empty, rx_overrun, rts_out, rx_dma_rdy;
    logic [1:0] trig_sel = 0;
    logic       auto_rts_en = 1, rts_manual = 0;
    logic       tx_wr = 0;
    logic [7:0] tx_wdata = 0, tx_char;
    logic       tx_full, tx_dma_rdy, tx_valid;
    logic       auto_cts_en = 0, cts_in = 0;
    logic       ser_take = 0, ser_done = 0;

    always #2 clk = ~clk;

    serial_flow_buffer i_serial_flow_buffer (
        .clk(clk), .rst_n(rst_n),
        .rx_push(rx_push), .rx_char(rx_char), .rx_err_in(rx_err_in),
        .rx_pop(rx_pop), .rx_head_char(rx_head_char), .rx_head_err(rx_head_err),
        .rx_level(rx_level), .rx_empty(rx_empty), .rx_overrun(rx_overrun),
        .ovr_clr(ovr_clr), .trig_sel(trig_sel), .auto_rts_en(auto_rts_en),
        .rts_manual(rts_manual), .rts_out(rts_out), .rx_dma_rdy(rx_dma_rdy),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_level(tx_level), .tx_full(tx_full),
        .tx_dma_rdy(tx_dma_rdy), .auto_cts_en(auto_cts_en), .cts_in(cts_in),
        .ser_take(ser_take), .ser_done(ser_done), .tx_valid(tx_valid), .tx_char(tx_char)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [10:0] rxq[$];
    logic [7:0]  txq[$];
    bit m_ovr, m_rts, m_rxrdy, m_txrdy;
    int m_st;          // 0 idle, 1 offering, 2 sending, 3 held
    int rl, tl, th, nst;
    bit cok, popt;

    function automatic int trig_val(input logic [1:0] s);
        case (s)
            2'd0: return 1;
            2'd1: return 16;
            2'd2: return 32;
            default: return 56;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            rxq.delete(); txq.delete();
            m_ovr = 0; m_rts = 1; m_rxrdy = 0; m_txrdy = 1; m_st = 0;
        end else begin
            rl  = rxq.size();
            tl  = txq.size();
            th  = trig_val(trig_sel);
            cok = !auto_cts_en || cts_in;
            m_rts = auto_rts_en ? (rl < th) : rts_manual;
            if (!m_rxrdy && rl >= th)     m_rxrdy = 1;
            else if (m_rxrdy && rl == 0)  m_rxrdy = 0;
            if (m_txrdy && tl == 64)      m_txrdy = 0;
            else if (!m_txrdy && tl == 0) m_txrdy = 1;
            nst = m_st;
            case (m_st)
                0: if (tl > 0) nst = cok ? 1 : 3;
                1: if (ser_take) nst = 2; else if (!cok) nst = 3;
                2: if (ser_done) nst = (tl == 0) ? 0 : (cok ? 1 : 3);
                default: if (tl == 0) nst = 0; else if (cok) nst = 1;
            endcase
            popt = (m_st == 1) && ser_take;
            m_st = nst;
            if (rx_pop && rl > 0) void'(rxq.pop_front());
            if (rx_push && rl < 64) rxq.push_back({rx_err_in, rx_char});
            if (rx_push && rl >= 64) m_ovr = 1;
            else if (ovr_clr)        m_ovr = 0;
            if (popt) void'(txq.pop_front());
            if (tx_wr && tl < 64) txq.push_back(tx_wdata);
        end
    end

    // Every-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(rx_level == rxq.size(), "R1", "rx_level", rx_level, rxq.size());
            chk(rx_empty == (rxq.size() == 0), "R1", "rx_empty", rx_empty, rxq.size() == 0);
            if (rxq.size() > 0)
                chk({rx_head_err, rx_head_char} == rxq[0], "R1", "rx_head", {rx_head_err, rx_head_char}, rxq[0]);
            chk(rx_overrun == m_ovr, "R2", "rx_overrun", rx_overrun, m_ovr);
            chk(tx_level == txq.size(), "R3", "tx_level", tx_level, txq.size());
            chk(tx_full == (txq.size() == 64), "R3", "tx_full", tx_full, txq.size() == 64);
            chk(rts_out == m_rts, auto_rts_en ? "R5" : "R6", "rts_out", rts_out, m_rts);
            chk(rx_dma_rdy == m_rxrdy, "R7", "rx_dma_rdy", rx_dma_rdy, m_rxrdy);
            chk(tx_dma_rdy == m_txrdy, "R8", "tx_dma_rdy", tx_dma_rdy, m_txrdy);
            chk(tx_valid == (m_st == 1), auto_cts_en ? "R9" : "R10", "tx_valid", tx_valid, m_st == 1);
            if (m_st == 1 && txq.size() > 0)
                chk(tx_char == txq[0], "R9", "tx_char", tx_char, txq[0]);
        end
    end

    // ---------------- serializer stand-in ----------------
    bit ser_en = 1;
    bit busy = 0;
    int cnt = 0;
    int dones = 0;

    always @(negedge clk) begin
        ser_take = 0;
        ser_done = 0;
        if (!rst_n) begin
            busy = 0;
        end else if (busy) begin
            cnt--;
            if (cnt == 0) begin
                ser_done = 1;
                busy = 0;
                dones++;
            end
        end else if (ser_en && tx_valid) begin
            ser_take = 1;
            busy = 1;
            cnt = 5;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired at %0t", $time);
            summary();
            $finish;
        end
    end

    // ---------------- stimulus ----------------
    initial begin
        step(3);
        rst_n = 1;
        step(1);
        // R12 reset values
        chk(rts_out == 1 && rx_dma_rdy == 0 && tx_dma_rdy == 1, "R12", "flow outputs",
            {rts_out, rx_dma_rdy, tx_dma_rdy}, 3'b101);
        chk(rx_empty == 1 && rx_level == 0 && tx_level == 0 && tx_valid == 0 && rx_overrun == 0,
            "R12", "buffers", {rx_empty, tx_valid, rx_overrun}, 3'b100);

        // R1 ordering with flags, simultaneous push and pop, then R11 pop on empty
        trig_sel = 2'd3;
        for (int i = 0; i < 5; i++) begin
            rx_push = 1; rx_char = 8'h30 + 8'(i); rx_err_in = 3'(i);
            step(1);
        end
        rx_push = 1; rx_pop = 1; rx_char = 8'hA5; rx_err_in = 3'b101;
        step(1);
        rx_push = 0;
        chk(rx_level == 5, "R1", "level after push+pop", rx_level, 5);
        step(6);
        rx_pop = 0;
        step(1);
        chk(rx_level == 0 && rx_empty == 1, "R11", "pop on empty", rx_level, 0);
        chk(rx_overrun == 0, "R11", "no overrun from pop", rx_overrun, 0);

        // R4/R5/R7 thresholds
        for (int s = 0; s < 4; s++) begin
            int t;
            trig_sel = 2'(s);
            t = trig_val(2'(s));
            rx_push = 1;
            for (int k = 0; k < t; k++) begin
                rx_char = 8'(k); rx_err_in = 3'(k);
                step(1);
            end
            rx_push = 0;
            step(2);
            chk(rts_out == 0 && rx_dma_rdy == 1, "R4", "threshold reached", {rts_out, rx_dma_rdy}, 2'b01);
            rx_pop = 1; step(1); rx_pop = 0;
            step(2);
            chk(rts_out == 1, "R5", "rts back below threshold", rts_out, 1);
            chk(rx_dma_rdy == (t > 1), "R7", "rxrdy hysteresis", rx_dma_rdy, t > 1);
            rx_pop = 1; step(t); rx_pop = 0;
            step(2);
            chk(rx_dma_rdy == 0, "R7", "rxrdy cleared on empty", rx_dma_rdy, 0);
        end

        // R2 overrun
        trig_sel = 2'd3;
        rx_push = 1;
        for (int k = 0; k < 66; k++) begin
            rx_char = 8'(k); rx_err_in = 3'd0;
            step(1);
        end
        rx_push = 0;
        step(1);
        chk(rx_overrun == 1 && rx_level == 64, "R2", "overrun", rx_level, 64);
        chk(rx_head_char == 8'd0, "R2", "oldest kept", rx_head_char, 0);
        step(3);
        chk(rx_overrun == 1, "R2", "overrun sticky", rx_overrun, 1);
        ovr_clr = 1; step(1); ovr_clr = 0;
        step(1);
        chk(rx_overrun == 0, "R2", "overrun cleared", rx_overrun, 0);
        rx_pop = 1; step(64); rx_pop = 0;
        step(2);

        // R6 manual RTS
        auto_rts_en = 0; rts_manual = 0;
        step(2);
        chk(rts_out == 0, "R6", "manual low", rts_out, 0);
        rts_manual = 1;
        step(2);
        chk(rts_out == 1, "R6", "manual high", rts_out, 1);
        auto_rts_en = 1;

        // R9 automatic CTS gating
        auto_cts_en = 1; cts_in = 0;
        for (int k = 0; k < 3; k++) begin
            tx_wr = 1; tx_wdata = 8'h50 + 8'(k);
            step(1);
        end
        tx_wr = 0;
        step(10);
        chk(tx_valid == 0 && tx_level == 3, "R9", "held while CTS low", tx_level, 3);
        dones = 0;
        cts_in = 1;
        @(posedge ser_take);
        cts_in = 0;
        step(20);
        chk(tx_level == 2 && dones == 1, "R9", "current char finished, next held", tx_level, 2);
        chk(tx_valid == 0, "R9", "no offer after CTS drop", tx_valid, 0);
        cts_in = 1;
        step(40);
        chk(tx_level == 0, "R9", "resumed", tx_level, 0);

        // R10 CTS ignored
        auto_cts_en = 0; cts_in = 0;
        for (int k = 0; k < 2; k++) begin
            tx_wr = 1; tx_wdata = 8'h60 + 8'(k);
            step(1);
        end
        tx_wr = 0;
        step(30);
        chk(tx_level == 0, "R10", "sent with CTS low", tx_level, 0);

        // R3/R8 full transmit buffer
        ser_en = 0;
        for (int k = 0; k < 66; k++) begin
            tx_wr = 1; tx_wdata = 8'(k + 1);
            step(1);
        end
        tx_wr = 0;
        step(2);
        chk(tx_level == 64 && tx_full == 1, "R3", "write to full dropped", tx_level, 64);
        chk(tx_char == 8'd1, "R3", "oldest kept", tx_char, 1);
        chk(tx_dma_rdy == 0, "R8", "txrdy off when full", tx_dma_rdy, 0);
        ser_en = 1;
        while (tx_level != 7'd63) @(negedge clk);
        step(1);
        chk(tx_dma_rdy == 0, "R8", "txrdy holds", tx_dma_rdy, 0);
        step(700);
        chk(tx_level == 0 && tx_dma_rdy == 1, "R8", "txrdy on when empty", tx_dma_rdy, 1);

        if (!finished) begin
            finished = 1;
            summary();
            $finish;
        end
    end

endmodule